// File: doc/BRIEF.md
# Stimulus Signature Retest Controller

This block confirms on chip that scan stimulus arriving over a multi-level test channel was received without corruption. Every decoded symbol accepted from the channel decoder is folded into a stimulus compactor, and the scan response bits captured on the same beat are folded into a response compactor. When the tester marks the final beat of a pass, the controller compares both signatures with expected values supplied by the tester. A stimulus signature mismatch points to a channel error, not a device defect, so the controller asks for the whole test set to be resent, up to a limit. A correct stimulus signature with a wrong response signature is a genuine device failure and ends the test at once.

The symbol input is a valid/ready stream. `sym_ready` is high only while a pass is being applied. A beat is taken on a rising clock edge where both `sym_valid` and `sym_ready` are high. While `sym_valid` is high and `sym_ready` is low, the sender must hold `sym_data`, `sym_last` and `resp_data` unchanged. `sym_ready` drops for at least two cycles after a beat that carries `sym_last`. The control and status pins are plain levels and pulses.

Top module: `sig_retest_ctrl`

## Requirements
- R1: `sym_ready` is 1 only between a `start` (or a retest) and the accepted beat that carries `sym_last`. In every other cycle it is 0, and `sym_valid` has no effect on either signature.
- R2: Each 16-bit compactor updates only on an accepted beat. The update is `next = {sig[14:0],0} ^ (sig[15] ? 16'h002D : 0) ^ in`, where `in` is the input zero-extended into bits [W-1:0]. On any other cycle the compactor holds its value.
- R3: Both compactors are loaded with 16'hFFFF when a pass starts from `start` and again at every retest.
- R4: The response compactor folds `resp_data` (4 bits) on the same accepted beats as the stimulus compactor, which folds `sym_data` (6 bits).
- R5: The signatures are compared in the cycle after the last beat is accepted. `done` or `retest_req` goes high one cycle after that, lasts exactly one cycle, and the two never coincide.
- R6: If both signatures match, `done` pulses with `pass` = 1 and `retests_used` = 0 if no retest occurred. `pass` holds until the next `start`.
- R7: If the stimulus signature matches and the response signature does not, `done` pulses with `pass` = 0 and no retest is requested.
- R8: If the stimulus signature mismatches and fewer retests than the limit have been used, `retest_req` pulses and `retests_used` goes up by one. The block then accepts a fresh pass without a new `start`.
- R9: If the stimulus signature mismatches after the limit has been reached, `done` pulses with `pass` = 0. A limit of 0 means a stimulus mismatch fails at once.
- R10: `max_retest` is sampled at `start`. Later changes to it do not affect the current test. `retests_used` reports the number of retests consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test when idle |
| max_retest | input | 4 | Retest limit, sampled at start |
| exp_ats | input | 16 | Expected stimulus signature |
| exp_trs | input | 16 | Expected response signature |
| sym_valid | input | 1 | Decoded symbol present |
| sym_ready | output | 1 | Block accepts symbols |
| sym_data | input | 6 | Decoded symbol |
| sym_last | input | 1 | Final beat of the pass |
| resp_data | input | 4 | Scan response bits of this beat |
| retest_req | output | 1 | One-cycle request to resend the test set |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Verdict, held until next start |
| retests_used | output | 4 | Retests consumed in this test |

## Verification
Take edge k as the edge where the last beat is accepted. The compare happens in the cycle after edge k, and the verdict or retest request is visible after edge k+1. The bench samples on falling edges. At the first falling edge after the last beat it expects `done` and `retest_req` both low. At the next falling edge it expects exactly the verdict or the request. At the falling edge after that it checks that the strobe has dropped. Expected signatures come from a bench model of the R2 polynomial over the bench's own symbol pattern.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;
  localparam int unsigned SIG_W = 16;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h002D;
  localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_CHECK,
    ST_RETEST,
    ST_PASS,
    ST_FAIL
  } ctl_state_t;
endpackage

// File: rtl/misr_comp.sv
module misr_comp
  import sigchk_pkg::*;
#(
  parameter int unsigned IN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [IN_W-1:0]  din,
  output logic [SIG_W-1:0] sig
);
  logic [SIG_W-1:0] din_ext;
  logic [SIG_W-1:0] fb;
  logic [SIG_W-1:0] nxt;

  assign din_ext = SIG_W'(din);
  assign fb      = sig[SIG_W-1] ? SIG_POLY : '0;
  assign nxt     = {sig[SIG_W-2:0], 1'b0} ^ fb ^ din_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sig <= SIG_SEED;
    else if (load) sig <= SIG_SEED;
    else if (en)   sig <= nxt;
  end

  // R2: no beat, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> $stable(sig));
  // R3: every seed load lands on the seed value
  p_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sig == SIG_SEED));
endmodule

// File: rtl/retest_fsm.sv
module retest_fsm
  import sigchk_pkg::*;
#(
  parameter int unsigned RC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            beat_last,
  input  logic            ats_ok,
  input  logic            trs_ok,
  input  logic [RC_W-1:0] max_retest,
  output logic            applying,
  output logic            seed_load,
  output logic            retest_req,
  output logic            done,
  output logic            pass,
  output logic [RC_W-1:0] retests_used
);
  ctl_state_t      state, nxt;
  logic [RC_W-1:0] used_q, limit_q;
  logic            pass_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_APPLY;
      ST_APPLY:  if (beat_last) nxt = ST_CHECK;
      ST_CHECK: begin
        if (ats_ok)                nxt = trs_ok ? ST_PASS : ST_FAIL;
        else if (used_q < limit_q) nxt = ST_RETEST;
        else                       nxt = ST_FAIL;
      end
      ST_RETEST: nxt = ST_APPLY;
      ST_PASS:   nxt = ST_IDLE;
      ST_FAIL:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      used_q  <= '0;
      limit_q <= '0;
      pass_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        used_q  <= '0;
        limit_q <= max_retest;
        pass_q  <= 1'b0;
      end else if (state == ST_RETEST) begin
        used_q <= used_q + RC_W'(1);
      end
      if (state == ST_CHECK && nxt == ST_PASS) pass_q <= 1'b1;
    end
  end

  assign applying     = (state == ST_APPLY);
  assign seed_load    = (state == ST_IDLE && start) || (state == ST_RETEST);
  assign retest_req   = (state == ST_RETEST);
  assign done         = (state == ST_PASS) || (state == ST_FAIL);
  assign pass         = pass_q;
  assign retests_used = used_q;

  // R5: strobes are single-cycle and never overlap
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, retest_req}));
  // R7: good stimulus, bad response fails without retest
  p_trs_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && ats_ok && !trs_ok) |=> (done && !pass));
  // R9: the retest count never exceeds the sampled limit
  p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= limit_q);
endmodule

// File: rtl/sig_retest_ctrl.sv
module sig_retest_ctrl
  import sigchk_pkg::*;
#(
  parameter int unsigned SYM_W  = 6,
  parameter int unsigned RESP_W = 4,
  parameter int unsigned RC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RC_W-1:0]   max_retest,
  input  logic [SIG_W-1:0]  exp_ats,
  input  logic [SIG_W-1:0]  exp_trs,
  input  logic              sym_valid,
  output logic              sym_ready,
  input  logic [SYM_W-1:0]  sym_data,
  input  logic              sym_last,
  input  logic [RESP_W-1:0] resp_data,
  output logic              retest_req,
  output logic              done,
  output logic              pass,
  output logic [RC_W-1:0]   retests_used
);
  logic             accept;
  logic             seed_load;
  logic [SIG_W-1:0] ats_sig;
  logic [SIG_W-1:0] trs_sig;

  assign accept = sym_valid && sym_ready;

  misr_comp #(.IN_W(SYM_W)) u_ats (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .en(accept),
    .din(sym_data), .sig(ats_sig)
  );

  misr_comp #(.IN_W(RESP_W)) u_trs (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .en(accept),
    .din(resp_data), .sig(trs_sig)
  );

  retest_fsm #(.RC_W(RC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .beat_last(accept && sym_last),
    .ats_ok(ats_sig == exp_ats), .trs_ok(trs_sig == exp_trs),
    .max_retest(max_retest), .applying(sym_ready), .seed_load(seed_load),
    .retest_req(retest_req), .done(done), .pass(pass),
    .retests_used(retests_used)
  );

  // R1: the last beat closes the input
  p_last_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sym_last) |=> !sym_ready);
  // R4: both compactors move together on a beat
  p_fold_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !seed_load) |=> ($stable(ats_sig) && $stable(trs_sig)));
endmodule

// File: tb/sig_retest_ctrl_test.sv
`timescale 1ns/1ps
module sig_retest_ctrl_test;
  localparam int NB = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  max_retest = '0;
  logic [15:0] exp_ats = '0, exp_trs = '0;
  logic        sym_valid = 1'b0, sym_last = 1'b0;
  logic [5:0]  sym_data = '0;
  logic [3:0]  resp_data = '0;
  logic        sym_ready, retest_req, done, pass;
  logic [3:0]  retests_used;

  int total = 0, bad = 0, rq_seen = 0;
  logic [15:0] good_ats, good_trs;

  sig_retest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_retest(max_retest),
    .exp_ats(exp_ats), .exp_trs(exp_trs), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_data(sym_data), .sym_last(sym_last),
    .resp_data(resp_data), .retest_req(retest_req), .done(done),
    .pass(pass), .retests_used(retests_used)
  );

  always #5 clk = ~clk;
  always @(negedge clk) if (retest_req) rq_seen++;

  function automatic logic [15:0] step(logic [15:0] s, logic [15:0] d);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h002D : 16'h0000) ^ d;
  endfunction
  function automatic logic [5:0] sym_of(int i);
    return 6'((i * 7 + 3) & 63);
  endfunction
  function automatic logic [3:0] resp_of(int i);
    return 4'((i * 5 + 1) & 15);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(logic [3:0] lim);
    @(negedge clk); start = 1'b1; max_retest = lim;
    @(negedge clk); start = 1'b0;
  endtask

  // drives one pass; returns at the falling edge after the last accepted beat
  task automatic send_pass(int bad_sym, int bad_resp, bit gaps);
    for (int i = 0; i < NB; i++) begin
      bit acc;
      if (gaps && (i % 3 == 1)) begin
        sym_valid = 1'b0;
        @(negedge clk);
      end
      sym_valid = 1'b1;
      sym_data  = sym_of(i) ^ ((i == bad_sym) ? 6'd1 : 6'd0);
      resp_data = resp_of(i) ^ ((i == bad_resp) ? 4'd2 : 4'd0);
      sym_last  = (i == NB - 1);
      acc = sym_ready;
      @(negedge clk);
      while (!acc) begin
        acc = sym_ready;
        @(negedge clk);
      end
    end
    sym_valid = 1'b0;
    sym_last  = 1'b0;
  endtask

  // at the compare cycle: no strobe yet; one cycle later the outcome
  task automatic expect_outcome(string tag, bit want_done, bit want_pass,
                                logic [3:0] want_used);
    check({tag, " R5 compare cycle quiet"}, {done, retest_req}, 2'b00);
    @(negedge clk);
    check({tag, " R5 done"}, done, want_done);
    check({tag, " R8 retest_req"}, retest_req, !want_done);
    if (want_done) begin
      check({tag, " R6 pass"}, pass, want_pass);
      check({tag, " R10 retests_used"}, retests_used, want_used);
    end
    @(negedge clk);
    check({tag, " R5 strobe drops"}, {done, retest_req}, 2'b00);
  endtask

  task automatic t_reset();
    check("R1 reset ready", sym_ready, 0);
    check("R5 reset done", done, 0);
    check("R6 reset pass", pass, 0);
    check("R8 reset retest_req", retest_req, 0);
  endtask

  task automatic t_clean_pass(bit gaps);
    exp_ats = good_ats; exp_trs = good_trs;
    pulse_start(4'd2);
    check("R1 ready in apply", sym_ready, 1);
    send_pass(-1, -1, gaps);
    check("R1 ready low after last", sym_ready, 0);
    expect_outcome(gaps ? "R2 gaps hold" : "R6 clean", 1, 1, 0);
  endtask

  task automatic t_resp_fail();
    int r0;
    r0 = rq_seen;
    exp_ats = good_ats; exp_trs = good_trs;
    pulse_start(4'd2);
    send_pass(-1, 4, 0);
    expect_outcome("R4 R7 response error", 1, 0, 0);
    check("R7 no retest requested", rq_seen, r0);
    exp_trs = good_trs ^ 16'h0100;
    pulse_start(4'd2);
    send_pass(-1, -1, 0);
    expect_outcome("R7 expected trs differs", 1, 0, 0);
  endtask

  task automatic t_retest_recover();
    exp_ats = good_ats; exp_trs = good_trs;
    pulse_start(4'd2);
    send_pass(5, -1, 0);
    expect_outcome("R8 first pass corrupt", 0, 0, 0);
    check("R8 count after retest", retests_used, 1);
    send_pass(-1, -1, 0);
    expect_outcome("R3 reseeded resend passes", 1, 1, 1);
  endtask

  task automatic t_exhaust();
    exp_ats = good_ats; exp_trs = good_trs;
    pulse_start(4'd2);
    max_retest = 4'd0;  // R10: ignored after start
    send_pass(0, -1, 0);
    expect_outcome("R8 exhaust pass1", 0, 0, 0);
    send_pass(NB - 1, -1, 0);
    expect_outcome("R8 exhaust pass2", 0, 0, 0);
    send_pass(3, -1, 0);
    expect_outcome("R9 R10 limit reached", 1, 0, 2);
  endtask

  task automatic t_zero_limit();
    exp_ats = good_ats; exp_trs = good_trs;
    pulse_start(4'd0);
    send_pass(7, -1, 0);
    expect_outcome("R9 zero limit", 1, 0, 0);
  endtask

  task automatic t_idle_ignored();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      sym_valid = 1'b1; sym_data = 6'(k + 9); resp_data = 4'(k); sym_last = k[0];
      check("R1 ready low in idle", sym_ready, 0);
    end
    @(negedge clk); sym_valid = 1'b0; sym_last = 1'b0;
    t_clean_pass(0);
  endtask

  initial begin
    logic [15:0] a, t;
    a = 16'hFFFF; t = 16'hFFFF;
    for (int i = 0; i < NB; i++) begin
      a = step(a, {10'd0, sym_of(i)});
      t = step(t, {12'd0, resp_of(i)});
    end
    good_ats = a; good_trs = t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_pass(0);
    t_clean_pass(1);
    t_resp_fail();
    t_retest_recover();
    t_exhaust();
    t_zero_limit();
    t_idle_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule